// File: doc/BRIEF.md
# FIFO Read-Side Retransmit Controller

This block owns the read pointer of a FIFO and adds a replay function to it. When the read side raises a retransmit request, the read pointer is rewound to location zero. The data then flows out again from the first word written after reset, and nothing already stored is discarded. The memory array and all write-side logic sit outside the block. The block sees the write side only through a count of the words written since reset, already present in the read-clock domain.

Two read modes are supported, selected by `mode_i`. In standard mode, `out_ready_o` is a plain not-empty indication, and each accepted read advances the pointer. In first-word-fall-through mode, the block keeps an output-stage valid bit and prefetches a word as soon as one is available, so `out_ready_o` means that a word is already presented. A retransmit passes through a short setup phase, during which `rt_busy_o` is high and read enables are ignored. The phase ends in a fixed way: after one cycle in standard mode, and in fall-through mode once the output-ready flag has dropped and the first word has been fetched again.

A request is honoured only when the written count is at least two and at most DEPTH-2. Within that window location zero still holds the first word, and the write side cannot reach full during setup.

Top module: `fifo_rt_ctrl`

## Requirements
- R1: A retransmit request that is accepted on a rising clock edge sets `rd_ptr_o` to 0 after that edge. Acceptance requires `rt_req_i`=1, `rt_busy_o`=0 and 2 <= `wr_cnt_i` <= DEPTH-2. `rt_busy_o` is then high.
- R2: A request made while `wr_cnt_i` < 2 is ignored: `rt_busy_o` stays 0 and `rd_ptr_o` is unchanged.
- R3: A request made while `wr_cnt_i` > DEPTH-2 is ignored: `rt_busy_o` stays 0 and `rd_ptr_o` is unchanged.
- R4: While `rt_busy_o` is 1, `rd_en_i` does not move the pointer beyond what setup itself does, and a further `rt_req_i` is not accepted.
- R5: In standard mode (`mode_i`=0), `rt_busy_o` is high for exactly one cycle after an accepted request, and `rd_ptr_o` remains 0 when it falls.
- R6: In fall-through mode (`mode_i`=1), `out_ready_o` is 0 in the cycle after an accepted request. On the next edge the word at location 0 is fetched: `rd_ptr_o` becomes 1, `out_ready_o` returns to 1, and `rt_busy_o` falls at that same edge.
- R7: In standard mode, `out_ready_o` is 1 exactly when `wr_cnt_i` differs from `rd_ptr_o`. When not busy, `rd_en_i`=1 with `out_ready_o`=1 increments `rd_ptr_o` by one; a read with `out_ready_o`=0 leaves it unchanged.
- R8: In fall-through mode, when no word is presented and `wr_cnt_i` differs from `rd_ptr_o`, the next edge fetches one word (`rd_ptr_o`+1, `out_ready_o`=1). `rd_en_i` with a presented word consumes it. The stage then refetches if more words remain, or otherwise drops `out_ready_o`.
- R9: When an acceptable request and `rd_en_i` arrive in the same cycle, the rewind wins and `rd_ptr_o` is 0 after the edge.
- R10: After reset, `rd_ptr_o`=0 and `rt_busy_o`=0, and `rd_ptr_o` never exceeds `wr_cnt_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rt_req_i | input | 1 | Retransmit request, sampled on rising edge |
| rd_en_i | input | 1 | Read enable |
| mode_i | input | 1 | 0 = standard, 1 = first-word-fall-through |
| wr_cnt_i | input | PTR_W | Words written since reset (read-clock domain) |
| rd_ptr_o | output | PTR_W | Read pointer (next location to read or fetch) |
| out_ready_o | output | 1 | Not-empty (standard) or word presented (fall-through) |
| rt_busy_o | output | 1 | Retransmit setup in progress |

## Verification
The collision that matters is a retransmit request arriving in the same cycle as a read enable. Both want to change the read pointer at one edge. The bench holds `rd_en_i` high across the request cycle and the whole setup phase, in both modes. It then checks that the pointer is 0 after the request edge and that the held read enable adds no extra advance during setup. It also checks that the first read after setup starts from location 0.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;

  localparam int unsigned RT_MIN_WORDS = 2;
endpackage

// File: rtl/rt_guard.sv
module rt_guard #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PTR_W = 5
) (
  input  logic             req_i,
  input  logic             busy_i,
  input  logic [PTR_W-1:0] wr_cnt_i,
  output logic             accept_o
);
  import fifo_rt_pkg::*;

  localparam logic [PTR_W-1:0] LoLim = PTR_W'(RT_MIN_WORDS);
  localparam logic [PTR_W-1:0] HiLim = PTR_W'(DEPTH - 2);

  // location 0 must still hold the first word and full must stay off
  assign accept_o = req_i && !busy_i && (wr_cnt_i >= LoLim) && (wr_cnt_i <= HiLim);
endmodule

// File: rtl/rt_occ.sv
module rt_occ #(
  parameter int unsigned PTR_W = 5
) (
  input  logic [PTR_W-1:0] wr_cnt_i,
  input  logic [PTR_W-1:0] rd_ptr_i,
  output logic             avail_o
);
  assign avail_o = (wr_cnt_i != rd_ptr_i);
endmodule

// File: rtl/rt_rdstate.sv
module rt_rdstate
  import fifo_rt_pkg::*;
#(
  parameter int unsigned PTR_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  rd_mode_e         mode_i,
  input  logic             accept_i,
  input  logic             rd_en_i,
  input  logic             avail_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             vld_o,
  output logic             busy_o
);
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             vld_q, vld_d;
  logic             busy_q, busy_d;

  always_comb begin
    ptr_d  = ptr_q;
    vld_d  = vld_q;
    busy_d = busy_q;
    if (accept_i) begin
      // rewind wins over any read in the same cycle
      ptr_d  = '0;
      vld_d  = 1'b0;
      busy_d = 1'b1;
    end else if (mode_i == MODE_STD) begin
      vld_d = 1'b0;
      if (busy_q) busy_d = 1'b0;
      else if (rd_en_i && avail_i) ptr_d = ptr_q + 1'b1;
    end else begin
      if (busy_q) begin
        // setup ends when word 0 is presented again
        if (avail_i) begin
          ptr_d  = ptr_q + 1'b1;
          vld_d  = 1'b1;
          busy_d = 1'b0;
        end
      end else if ((!vld_q || rd_en_i) && avail_i) begin
        ptr_d = ptr_q + 1'b1;
        vld_d = 1'b1;
      end else if (rd_en_i) begin
        vld_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      vld_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      vld_q  <= vld_d;
      busy_q <= busy_d;
    end
  end

  assign ptr_o  = ptr_q;
  assign vld_o  = vld_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/fifo_rt_ctrl.sv
module fifo_rt_ctrl #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PTR_W = $clog2(DEPTH + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rt_req_i,
  input  logic             rd_en_i,
  input  logic             mode_i,
  input  logic [PTR_W-1:0] wr_cnt_i,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic             out_ready_o,
  output logic             rt_busy_o
);
  import fifo_rt_pkg::*;

  rd_mode_e         mode;
  logic             accept, avail, vld, busy;
  logic [PTR_W-1:0] ptr;

  assign mode = rd_mode_e'(mode_i);

  rt_guard #(.DEPTH(DEPTH), .PTR_W(PTR_W)) i_guard (
    .req_i    (rt_req_i),
    .busy_i   (busy),
    .wr_cnt_i (wr_cnt_i),
    .accept_o (accept)
  );

  rt_occ #(.PTR_W(PTR_W)) i_occ (
    .wr_cnt_i (wr_cnt_i),
    .rd_ptr_i (ptr),
    .avail_o  (avail)
  );

  rt_rdstate #(.PTR_W(PTR_W)) i_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .accept_i (accept),
    .rd_en_i  (rd_en_i),
    .avail_i  (avail),
    .ptr_o    (ptr),
    .vld_o    (vld),
    .busy_o   (busy)
  );

  assign rd_ptr_o    = ptr;
  assign rt_busy_o   = busy;
  assign out_ready_o = (mode == MODE_FWFT) ? vld : avail;
endmodule

// File: rtl/fifo_rt_ctrl_chk.sv
module fifo_rt_ctrl_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PTR_W = $clog2(DEPTH + 2)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rt_req_i,
  input logic             rd_en_i,
  input logic             mode_i,
  input logic [PTR_W-1:0] wr_cnt_i,
  input logic [PTR_W-1:0] rd_ptr_o,
  input logic             out_ready_o,
  input logic             rt_busy_o
);
  logic ok_win, req_ok;
  assign ok_win = (wr_cnt_i >= PTR_W'(2)) && (wr_cnt_i <= PTR_W'(DEPTH - 2));
  assign req_ok = rt_req_i && !rt_busy_o && ok_win;

  p_rewind_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ok |=> (rd_ptr_o == '0) && rt_busy_o);

  p_early_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rt_req_i && !rt_busy_o && wr_cnt_i < PTR_W'(2)) |=> !rt_busy_o);

  p_late_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rt_req_i && !rt_busy_o && wr_cnt_i > PTR_W'(DEPTH - 2)) |=> !rt_busy_o);

  p_std_setup_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rt_busy_o && !mode_i) |=> !rt_busy_o && (rd_ptr_o == '0));

  p_fwft_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rt_busy_o && mode_i) |-> !out_ready_o);

  p_fwft_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rt_busy_o && mode_i) |=> !rt_busy_o && out_ready_o && (rd_ptr_o == PTR_W'(1)));

  p_collide_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ok && rd_en_i) |=> (rd_ptr_o == '0));

  p_no_overread_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ptr_o <= wr_cnt_i);
endmodule

bind fifo_rt_ctrl fifo_rt_ctrl_chk #(.DEPTH(DEPTH)) i_chk (.*);

// File: tb/test_fifo_rt_ctrl.sv
`timescale 1ns/1ps
module test_fifo_rt_ctrl;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned PTR_W = $clog2(DEPTH + 2);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rt_req = 1'b0;
  logic             rd_en = 1'b0;
  logic             mode = 1'b0;
  logic [PTR_W-1:0] wr_cnt = '0;
  logic [PTR_W-1:0] rd_ptr;
  logic             out_ready, rt_busy;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  fifo_rt_ctrl #(.DEPTH(DEPTH)) i_fifo_rt_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rt_req_i    (rt_req),
    .rd_en_i     (rd_en),
    .mode_i      (mode),
    .wr_cnt_i    (wr_cnt),
    .rd_ptr_o    (rd_ptr),
    .out_ready_o (out_ready),
    .rt_busy_o   (rt_busy)
  );

  task automatic chk(string req, int ptr_e, bit rdy_e, bit busy_e);
    n_chk++;
    if (int'(rd_ptr) != ptr_e || out_ready != rdy_e || rt_busy != busy_e) begin
      n_fail++;
      $display("FAIL %s: ptr/ready/busy = %0d/%0b/%0b expected %0d/%0b/%0b",
               req, rd_ptr, out_ready, rt_busy, ptr_e, rdy_e, busy_e);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(bit m, int cnt);
    rst_n = 1'b0; rt_req = 1'b0; rd_en = 1'b0;
    mode = m; wr_cnt = PTR_W'(cnt);
    step(); step();
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset(1'b0, 0);
    chk("R10 reset std", 0, 1'b0, 1'b0);
    step();
    chk("R7 empty stays", 0, 1'b0, 1'b0);
  endtask

  task automatic t_std_read();
    do_reset(1'b0, 5);
    chk("R7 not empty", 0, 1'b1, 1'b0);
    rd_en = 1'b1;
    step(); step(); step();
    chk("R7 three reads", 3, 1'b1, 1'b0);
    step(); step();
    chk("R7 drained", 5, 1'b0, 1'b0);
    step();
    chk("R7 read when empty", 5, 1'b0, 1'b0);
    rd_en = 1'b0;
  endtask

  task automatic t_std_rt_collide();
    // continues from ptr 5, wr_cnt 5
    rt_req = 1'b1; rd_en = 1'b1;
    step();
    chk("R1 R9 std rewind", 0, 1'b1, 1'b1);
    rt_req = 1'b1;
    step();
    chk("R4 R5 std setup one cycle", 0, 1'b1, 1'b0);
    rt_req = 1'b0;
    step();
    chk("R1 read restarts at 0", 1, 1'b1, 1'b0);
    rd_en = 1'b0;
  endtask

  task automatic t_guard_low();
    do_reset(1'b0, 1);
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
    chk("R7 single read", 1, 1'b0, 1'b0);
    rt_req = 1'b1;
    step();
    rt_req = 1'b0;
    chk("R2 early request ignored", 1, 1'b0, 1'b0);
  endtask

  task automatic t_guard_high();
    do_reset(1'b0, DEPTH - 1);
    rd_en = 1'b1;
    step(); step();
    rd_en = 1'b0;
    rt_req = 1'b1;
    step();
    rt_req = 1'b0;
    chk("R3 late request ignored", 2, 1'b1, 1'b0);
    wr_cnt = PTR_W'(DEPTH - 2);
    rt_req = 1'b1;
    step();
    rt_req = 1'b0;
    chk("R3 R1 limit accepted", 0, 1'b1, 1'b1);
  endtask

  task automatic t_fwft();
    do_reset(1'b1, 0);
    chk("R10 reset fwft", 0, 1'b0, 1'b0);
    wr_cnt = PTR_W'(3);
    step();
    chk("R8 prefetch", 1, 1'b1, 1'b0);
    step();
    chk("R8 holds without read", 1, 1'b1, 1'b0);
    rd_en = 1'b1;
    step(); step();
    chk("R8 pop and refetch", 3, 1'b1, 1'b0);
    step();
    chk("R8 last word consumed", 3, 1'b0, 1'b0);
    rt_req = 1'b1;
    step();
    chk("R6 R9 fwft ready low", 0, 1'b0, 1'b1);
    step();
    rt_req = 1'b0;
    chk("R6 R4 word 0 presented", 1, 1'b1, 1'b0);
    rd_en = 1'b0;
    step();
    chk("R8 idle after setup", 1, 1'b1, 1'b0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_std_read();
        t_std_rt_collide();
        t_guard_low();
        t_guard_high();
        t_fwft();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule